// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Front End

This block sits between an asynchronous host bus and the register file of a peripheral. It runs entirely on the system clock. A static mode pin selects one of two bus styles. In strobe style the host drives a chip select together with separate active-low read and write strobes, and the block produces no acknowledge. In acknowledge style the host drives a chip select with a single read/write direction line, and the block answers with an active-low data acknowledge. Every bus input is resynchronised through two flops before any decision is made. Edges are then found in the clock domain.

Writes leave the block on a valid/ready request port. The port carries the address and data that the host held before the access ended. The commit happens on whichever terminating event arrives first, and each access commits exactly once. Reads present the synchronised address to the register file, which answers combinationally. The block registers the answer onto a split tri-state bus, made of a data output and an output enable. An interrupt-acknowledge input works as a special read: it needs no chip select, and it places the supplied interrupt vector on the bus in place of register data.

The write request port applies back-pressure in the usual way. Once `wr_valid` is high, the address and data stay frozen until a clock edge where `wr_ready` is also high. The host side cannot be stalled. The next commit must therefore not arrive while a request is still waiting.

Top module: `hostbus_frontend`

## Requirements
- R1: While reset is held, and right after it is released, `bus_data_oe` is 0, `bus_dack_n` is 1 and `wr_valid` is 0.
- R2: In strobe style (`mode_ack`=0), `bus_dack_n` never goes low.
- R3: In strobe style, a write access (`bus_cs_n` and `bus_wr_n` both low) produces exactly one write request. The request carries the address and data present before the first of `bus_cs_n` or `bus_wr_n` rose. This holds when either one rises first and when both rise together, and the bus may change at that same moment.
- R4: A read drives `bus_data_oe`=1 three clock edges after the read condition appears on the pins, and not after two. The data is `rd_data` for the held address. The read condition is `bus_cs_n` and `bus_rd_n` both low in strobe style, or `bus_cs_n` low with `bus_rw`=1 in acknowledge style.
- R5: `bus_data_oe` falls three clock edges after the chip select or the read condition is removed, and is still high after two.
- R6: In acknowledge style, `bus_dack_n` goes low four clock edges after `bus_cs_n` falls. That is two clocks after the access is recognised. It is still high after three edges. It returns high two edges after `bus_cs_n` rises.
- R7: In acknowledge style, a write (`bus_rw`=0) commits when the acknowledge falls, so `wr_valid` rises five edges after `bus_cs_n` falls, while the chip select is still low. If the chip select rises before the acknowledge would fall, the write commits on that rise instead and no acknowledge is produced. Either way, exactly one request is made per access.
- R8: In acknowledge style, read data is on the bus, with the enable high, at least one clock before `bus_dack_n` falls.
- R9: With `bus_inta_n` low and the read condition met (a low read strobe, or `bus_rw`=1 in acknowledge style), the bus carries `irq_vector` and no chip select is needed. In acknowledge style the acknowledge is produced as for a chip-select read.
- R10: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr` and `wr_data` keep their values on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ack | input | 1 | Static bus style: 0 strobe, 1 acknowledge |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low (strobe style) |
| bus_wr_n | input | 1 | Write strobe, active low (strobe style) |
| bus_rw | input | 1 | Direction, 1 read / 0 write (acknowledge style) |
| bus_inta_n | input | 1 | Interrupt acknowledge, active low |
| bus_addr | input | AW | Register address |
| bus_data_in | input | DW | Write data from host |
| bus_data_out | output | DW | Read data toward host |
| bus_data_oe | output | 1 | Output enable for bus_data_out |
| bus_dack_n | output | 1 | Data acknowledge, active low |
| rd_addr | output | AW | Synchronised register read address |
| rd_data | input | DW | Register read data for rd_addr |
| irq_vector | input | DW | Vector returned on interrupt acknowledge |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted by register file |
| wr_addr | output | AW | Write request address |
| wr_data | output | DW | Write request data |

## Verification
The checks assume the following about the inputs:
- `mode_ack` changes only while the bus is idle.
- Address, data and direction stay steady for at least one clock before an access ends.
- A new write never commits while the previous request is still stalled.

The stimulus respects each of these. It switches mode only between accesses, with idle gaps. It changes the bus no earlier than the terminating edge. It holds `wr_ready` low for no more than two cycles in a row, against idle gaps of eight or more cycles. Random access types, holds and release orders are mixed with directed cases. The directed cases include a simultaneous release of both strobes, a short acknowledge-style write, and interrupt-acknowledge reads in both styles.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  typedef enum logic {
    BUS_STROBE = 1'b0,
    BUS_ACK    = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hbf_dack_timer.sv
module hbf_dack_timer #(
  parameter int ACK_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sel,
  output logic dack_on,
  output logic dack_rise
);
  localparam int CW = $clog2(ACK_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_DLY);

  logic [CW-1:0] cnt;
  logic          dack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dack_q <= 1'b0;
    end else begin
      if (!enable || !sel)  cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
      dack_q <= dack_on;
    end
  end

  assign dack_on   = enable && sel && (cnt == LAST);
  assign dack_rise = dack_on && !dack_q;

  // R6: acknowledge only after the access was already seen on the previous edge
  a_r6_dack_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
    dack_on |-> $past(sel));
endmodule

// File: rtl/hbf_wr_commit.sv
module hbf_wr_commit #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_mode,
  input  logic          cs_act,
  input  logic          wr_s,
  input  logic          rw_s,
  input  logic          dack_rise,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  input  logic          wr_ready,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int PW = AW + DW;

  logic          wact, wact_d, committed, commit;
  logic          commit_strobe, commit_ack;
  logic [PW-1:0] lat, payload;

  assign wact = cs_act && (ack_mode ? !rw_s : !wr_s);

  assign commit_strobe = !ack_mode && wact_d && !wact;
  assign commit_ack    = ack_mode && !committed &&
                         ((dack_rise && wact) || (wact_d && !cs_act));
  assign commit        = commit_strobe || commit_ack;
  assign payload       = wact ? {addr_s, data_s} : lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wact_d    <= 1'b0;
      lat       <= '0;
      committed <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wact_d <= wact;
      if (wact) lat <= {addr_s, data_s};
      if (commit)       committed <= 1'b1;
      else if (!cs_act) committed <= 1'b0;
      if (commit) begin
        wr_valid <= 1'b1;
        {wr_addr, wr_data} <= payload;
      end else if (wr_ready) begin
        wr_valid <= 1'b0;
      end
    end
  end

  // R7: one access never yields back-to-back commits
  a_r7_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R10: stalled request is frozen
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R10: input assumption, no commit onto a stalled request
  a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !(wr_valid && !wr_ready));
endmodule

// File: rtl/hostbus_frontend.sv
module hostbus_frontend
  import hbf_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int ACK_DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ack,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic          bus_rw,
  input  logic          bus_inta_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data_in,
  output logic [DW-1:0] bus_data_out,
  output logic          bus_data_oe,
  output logic          bus_dack_n,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] irq_vector,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int NS = 5;
  localparam int PW = AW + DW;

  bus_mode_e     mode;
  logic [NS-1:0] strb_s;
  logic [PW-1:0] pay_s;
  logic          cs_s, rd_s, wr_s, rw_s, inta_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;
  logic          cs_act, inta_act, sel, rd_act;
  logic          dack_on, dack_rise;
  logic [DW-1:0] src;

  assign mode = bus_mode_e'(mode_ack);

  hbf_sync #(.W(NS), .RST_VAL({NS{1'b1}})) u_sync_strb (
    .clk(clk), .rst_n(rst_n),
    .d({bus_cs_n, bus_rd_n, bus_wr_n, bus_rw, bus_inta_n}),
    .q(strb_s)
  );

  hbf_sync #(.W(PW), .RST_VAL('0)) u_sync_pay (
    .clk(clk), .rst_n(rst_n),
    .d({bus_addr, bus_data_in}),
    .q(pay_s)
  );

  assign {cs_s, rd_s, wr_s, rw_s, inta_s} = strb_s;
  assign {addr_s, data_s} = pay_s;

  assign cs_act   = !cs_s;
  assign inta_act = !inta_s;
  assign sel      = cs_act || inta_act;
  assign rd_act   = sel && ((mode == BUS_ACK) ? rw_s : !rd_s);
  assign src      = inta_act ? irq_vector : rd_data;
  assign rd_addr  = addr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_data_oe  <= 1'b0;
      bus_data_out <= '0;
    end else begin
      bus_data_oe  <= rd_act;
      bus_data_out <= rd_act ? src : '0;
    end
  end

  hbf_dack_timer #(.ACK_DLY(ACK_DLY)) u_dack (
    .clk(clk), .rst_n(rst_n),
    .enable(mode == BUS_ACK),
    .sel(sel),
    .dack_on(dack_on),
    .dack_rise(dack_rise)
  );

  assign bus_dack_n = !dack_on;

  hbf_wr_commit #(.AW(AW), .DW(DW)) u_commit (
    .clk(clk), .rst_n(rst_n),
    .ack_mode(mode == BUS_ACK),
    .cs_act(cs_act),
    .wr_s(wr_s),
    .rw_s(rw_s),
    .dack_rise(dack_rise),
    .addr_s(addr_s),
    .data_s(data_s),
    .wr_ready(wr_ready),
    .wr_valid(wr_valid),
    .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  // R8: read data is already enabled when the acknowledge falls
  a_r8_data_before_dack: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_rise && rd_act) |-> bus_data_oe);
endmodule

// File: tb/test_hostbus_frontend.sv
module test_hostbus_frontend;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, mode_ack, bus_cs_n, bus_rd_n, bus_wr_n, bus_rw, bus_inta_n;
  logic [AW-1:0] bus_addr, rd_addr, wr_addr;
  logic [DW-1:0] bus_data_in, bus_data_out, rd_data, irq_vector, wr_data;
  logic          bus_data_oe, bus_dack_n, wr_valid, wr_ready;

  hostbus_frontend #(.AW(AW), .DW(DW), .ACK_DLY(2)) i_hostbus_frontend (
    .clk(clk), .rst_n(rst_n), .mode_ack(mode_ack),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_rw(bus_rw), .bus_inta_n(bus_inta_n),
    .bus_addr(bus_addr), .bus_data_in(bus_data_in),
    .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .bus_dack_n(bus_dack_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_vector(irq_vector), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
    return 8'({4'h0, a} * 8'd37 + 8'd5);
  endfunction
  assign rd_data = rd_model(rd_addr);

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int wcount = 0, strobe_dack = 0, low_run = 0;
  logic [AW-1:0] last_wa = '0, stall_a = '0;
  logic [DW-1:0] last_wd = '0, stall_d = '0;
  logic stall_q = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // request port monitor (R10 stall hold, write capture)
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mode_ack && !bus_dack_n) strobe_dack++;
      if (stall_q)
        chk(wr_valid && wr_addr == stall_a && wr_data == stall_d,
            "R10", "stalled request changed", int'(wr_data), int'(stall_d));
      stall_q = wr_valid && !wr_ready;
      stall_a = wr_addr;
      stall_d = wr_data;
      if (wr_valid && wr_ready) begin
        wcount++;
        last_wa = wr_addr;
        last_wd = wr_data;
      end
    end
  end

  // back-pressure: low at most two cycles in a row
  always @(posedge clk) begin
    #1;
    if (low_run >= 2) begin wr_ready = 1'b1; low_run = 0; end
    else if ($urandom % 3 == 0) begin wr_ready = 1'b0; low_run++; end
    else begin wr_ready = 1'b1; low_run = 0; end
  end

  task automatic s_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int how, input int hold);
    int c0;
    c0 = wcount;
    @(negedge clk);
    bus_addr = a; bus_data_in = d; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
    idle(hold);
    @(negedge clk);
    bus_addr = AW'($urandom); bus_data_in = DW'($urandom);
    if (how == 0) bus_wr_n = 1'b1;
    else if (how == 1) bus_cs_n = 1'b1;
    else begin bus_wr_n = 1'b1; bus_cs_n = 1'b1; end
    idle(2);
    bus_cs_n = 1'b1; bus_wr_n = 1'b1;
    idle(8);
    chk(wcount == c0 + 1, "R3", "strobe write count", wcount - c0, 1);
    chk(last_wa == a && last_wd == d, "R3", "strobe write data", int'(last_wd), int'(d));
  endtask

  task automatic s_read(input logic [AW-1:0] a, input bit intack);
    logic [DW-1:0] exp;
    exp = intack ? irq_vector : rd_model(a);
    @(negedge clk);
    bus_addr = a; bus_rd_n = 1'b0;
    if (intack) bus_inta_n = 1'b0; else bus_cs_n = 1'b0;
    idle(2);
    chk(!bus_data_oe, "R4", "enable too early", int'(bus_data_oe), 0);
    idle(1);
    chk(bus_data_oe, "R4", "enable on third edge", int'(bus_data_oe), 1);
    if (intack) chk(bus_data_out == exp, "R9", "vector on bus", int'(bus_data_out), int'(exp));
    else        chk(bus_data_out == exp, "R4", "read data", int'(bus_data_out), int'(exp));
    idle(2);
    bus_rd_n = 1'b1;
    idle(2);
    chk(bus_data_oe, "R5", "enable held two edges", int'(bus_data_oe), 1);
    idle(1);
    chk(!bus_data_oe, "R5", "enable off after strobe", int'(bus_data_oe), 0);
    bus_cs_n = 1'b1; bus_inta_n = 1'b1;
    idle(4);
  endtask

  task automatic a_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int extra);
    int c0;
    c0 = wcount;
    @(negedge clk);
    bus_addr = a; bus_data_in = d; bus_rw = 1'b0; bus_cs_n = 1'b0;
    idle(3);
    chk(bus_dack_n, "R6", "ack too early", int'(bus_dack_n), 1);
    idle(1);
    chk(!bus_dack_n, "R6", "ack on fourth edge", int'(bus_dack_n), 0);
    chk(!wr_valid, "R7", "commit before ack", int'(wr_valid), 0);
    idle(1);
    chk(wr_valid, "R7", "commit at ack fall", int'(wr_valid), 1);
    idle(extra);
    bus_addr = AW'($urandom); bus_data_in = DW'($urandom); bus_cs_n = 1'b1;
    idle(1);
    chk(!bus_dack_n, "R6", "ack held one edge", int'(bus_dack_n), 0);
    idle(1);
    chk(bus_dack_n, "R6", "ack released", int'(bus_dack_n), 1);
    bus_rw = 1'b1;
    idle(6);
    chk(wcount == c0 + 1, "R7", "ack write count", wcount - c0, 1);
    chk(last_wa == a && last_wd == d, "R7", "ack write data", int'(last_wd), int'(d));
  endtask

  task automatic a_short_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int c0, lows;
    c0 = wcount; lows = 0;
    @(negedge clk);
    bus_addr = a; bus_data_in = d; bus_rw = 1'b0; bus_cs_n = 1'b0;
    idle(2);
    bus_addr = AW'($urandom); bus_data_in = DW'($urandom); bus_cs_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!bus_dack_n) lows++;
    end
    bus_rw = 1'b1;
    idle(2);
    chk(lows == 0, "R7", "no ack on short write", lows, 0);
    chk(wcount == c0 + 1, "R7", "short write count", wcount - c0, 1);
    chk(last_wa == a && last_wd == d, "R7", "short write data", int'(last_wd), int'(d));
  endtask

  task automatic a_read(input logic [AW-1:0] a, input bit intack);
    logic [DW-1:0] exp;
    exp = intack ? irq_vector : rd_model(a);
    @(negedge clk);
    bus_addr = a; bus_rw = 1'b1;
    if (intack) bus_inta_n = 1'b0; else bus_cs_n = 1'b0;
    idle(2);
    chk(!bus_data_oe, "R4", "ack-style enable early", int'(bus_data_oe), 0);
    idle(1);
    chk(bus_data_oe && bus_dack_n, "R8", "data before ack", int'(bus_data_oe), 1);
    if (intack) chk(bus_data_out == exp, "R9", "ack-style vector", int'(bus_data_out), int'(exp));
    else        chk(bus_data_out == exp, "R4", "ack-style data", int'(bus_data_out), int'(exp));
    idle(1);
    chk(!bus_dack_n, "R6", "read ack", int'(bus_dack_n), 0);
    idle(1);
    bus_cs_n = 1'b1; bus_inta_n = 1'b1;
    idle(2);
    chk(bus_data_oe && bus_dack_n, "R5", "ack off, enable still on", int'(bus_data_oe), 1);
    idle(1);
    chk(!bus_data_oe, "R5", "enable off after select", int'(bus_data_oe), 0);
    idle(4);
  endtask

  task automatic set_mode(input bit m);
    mode_ack = m;
    idle(3);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; mode_ack = 1'b0;
    bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_rw = 1'b1; bus_inta_n = 1'b1;
    bus_addr = '0; bus_data_in = '0; irq_vector = 8'hA5; wr_ready = 1'b1;
    idle(4);
    chk(!bus_data_oe && bus_dack_n && !wr_valid, "R1", "state in reset", int'(bus_data_oe), 0);
    rst_n = 1'b1;
    idle(2);
    chk(!bus_data_oe && bus_dack_n && !wr_valid, "R1", "state after reset", int'(wr_valid), 0);

    set_mode(1'b0);
    s_write(4'h3, 8'h5C, 0, 2);
    s_write(4'hA, 8'hC3, 1, 3);
    s_write(4'hF, 8'hFF, 2, 1);
    s_read(4'h7, 1'b0);
    s_read(4'h0, 1'b1);
    set_mode(1'b1);
    a_write(4'h9, 8'h12, 2);
    a_short_write(4'h4, 8'h81);
    a_read(4'hB, 1'b0);
    irq_vector = 8'h3E;
    a_read(4'h2, 1'b1);

    for (int it = 0; it < 40; it++) begin
      int op;
      op = int'($urandom % 6);
      irq_vector = DW'($urandom);
      set_mode(op >= 3);
      case (op)
        0: s_write(AW'($urandom), DW'($urandom), int'($urandom % 3), 1 + int'($urandom % 4));
        1: s_read(AW'($urandom), 1'b0);
        2: s_read(AW'($urandom), 1'b1);
        3: a_write(AW'($urandom), DW'($urandom), 2 + int'($urandom % 3));
        4: a_short_write(AW'($urandom), DW'($urandom));
        default: a_read(AW'($urandom), ($urandom % 2) == 1);
      endcase
    end

    chk(strobe_dack == 0, "R2", "ack cycles in strobe style", strobe_dack, 0);
    summary();
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule